// File: doc/BRIEF.md
# Elastic-Buffer Jitter Smoother

This block takes a serial bit stream whose write strobes arrive at uneven times and puts it out with evenly spaced read strobes. Writes may come in bursts, after gaps, or with slow phase wander. Everything runs on one system clock of nominally 32.768 MHz. Each write is a one-cycle strobe that is already synchronous to that clock. A one-bit-wide ring of cells absorbs the difference between when bits arrive and when they leave. A read pacer divides the system clock to set the output rate: by 16 normally, which gives 2.048 MHz.

The buffer has two capacities. The deep setting holds 128 bits and tolerates large wander. The shallow setting holds 32 bits and keeps the delay low. The pacer checks the fill level at each read. When the level has drifted more than half the allowed jitter span away from the centre, the next read interval is shortened to 15 clocks or stretched to 17 clocks, and a sticky trip flag records that this happened. The allowed span is 120 bits when deep and 28 bits when shallow. A bypass input routes the raw write strobe and data straight to the outputs.

Top module: `jitter_smoother`

## Requirements
- R1: While reset is held and on the first cycle after it, rd_stb, rd_bit, trip, ovf and udf are all 0.
- R2: When deep_sel is 1 the buffer holds 128 bits, and when it is 0 it holds 32 bits. Any change of deep_sel empties the buffer and restarts the warm-up phase.
- R3: With the fill level inside its band, consecutive rd_stb pulses are exactly 16 clocks apart.
- R4: At each read the fill level is compared with two marks. Above depth/2 + span/2 (124 deep, 30 shallow), the next read interval is 15 clocks. Below depth/2 − span/2 (4 deep, 2 shallow), the next interval is 17 clocks. Read intervals only ever take the values 15, 16 or 17.
- R5: trip is set whenever a 15- or 17-clock interval is chosen. It stays set until a one-cycle flag_clr pulse arrives. A new trip in the same cycle as the clear wins.
- R6: After reset, a depth change or bypass, no read happens until the fill has reached exactly half the selected depth.
- R7: The bits leaving on rd_bit, taken at rd_stb, are the accepted written bits in the same order, with no loss, for periodic, bursty and wandering write patterns. rd_stb and rd_bit appear one clock after the internal read decision.
- R8: While bypass is 1, rd_stb equals wr_stb and rd_bit equals wr_bit in the same cycle. The buffer is emptied. trip, ovf and udf keep their values.
- R9: A write arriving while the fill equals the selected depth is dropped, and the sticky ovf flag is set. flag_clr clears ovf.
- R10: When a read falls due with the buffer empty, rd_stb still pulses, rd_bit repeats the previous bit, and the sticky udf flag is set.
- R11: Write phase wander below the selected limit (20 UI peak-to-peak shallow, 80 deep) never sets trip. Wander above it (32 UI peak-to-peak shallow) does set trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, nominally 32.768 MHz |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle write strobe, already synchronous |
| wr_bit | input | 1 | Data bit taken with wr_stb |
| deep_sel | input | 1 | 1 selects 128-bit capacity, 0 selects 32-bit capacity |
| bypass | input | 1 | 1 routes write strobe and data directly to the outputs |
| flag_clr | input | 1 | One-cycle pulse that clears trip, ovf and udf |
| rd_stb | output | 1 | Evenly paced read strobe |
| rd_bit | output | 1 | Data bit valid with rd_stb |
| trip | output | 1 | Sticky flag: the pacer has used 15 or 17 |
| ovf | output | 1 | Sticky flag: a write was dropped on full |
| udf | output | 1 | Sticky flag: a read found the buffer empty |

## Verification
The assertions take three things for granted about the inputs:
- wr_stb is a single-cycle pulse already aligned to clk.
- deep_sel and bypass change only when losing the buffered bits is acceptable.
- flag_clr is a short pulse.

On that basis they reason about fill movement, pacer reload values and how the sticky flags hold.

The stimulus keeps to these assumptions. Every write is one cycle wide, and the average write spacing is always exactly 16 clocks: plain periodic writes, 24/8-clock triangles of phase wander, and 48-clock gaps followed by four quick writes. Depth and bypass are switched only while the data scoreboard is paused. Deliberate overflow and underflow are provoked only in separate, unscored phases.

// File: rtl/jsm_pkg.sv
package jsm_pkg;

    localparam int unsigned DEEP_BITS    = 128;
    localparam int unsigned SHALLOW_BITS = 32;
    localparam int unsigned DEEP_SPAN    = 120;
    localparam int unsigned SHALLOW_SPAN = 28;
    localparam int unsigned NOM_DIV      = 16;

    localparam int unsigned FILL_W = $clog2(DEEP_BITS) + 1;
    localparam int unsigned ADDR_W = $clog2(DEEP_BITS);
    localparam int unsigned DIV_W  = $clog2(NOM_DIV + 2);

    typedef logic [FILL_W-1:0] fill_t;

    typedef enum logic [1:0] {
        PACE_NOM  = 2'd0,
        PACE_FAST = 2'd1,
        PACE_SLOW = 2'd2
    } pace_e;

    typedef struct packed {
        fill_t depth;
        fill_t half;
        fill_t hi;
        fill_t lo;
    } marks_t;

    function automatic marks_t marks_for(logic deep);
        marks_t m;
        int unsigned bits;
        int unsigned span;
        bits    = deep ? DEEP_BITS : SHALLOW_BITS;
        span    = deep ? DEEP_SPAN : SHALLOW_SPAN;
        m.depth = fill_t'(bits);
        m.half  = fill_t'(bits / 2);
        m.hi    = fill_t'(bits / 2 + span / 2);
        m.lo    = fill_t'(bits / 2 - span / 2);
        return m;
    endfunction

    function automatic pace_e pace_pick(fill_t lvl, marks_t m);
        if (lvl > m.hi) return PACE_FAST;
        if (lvl < m.lo) return PACE_SLOW;
        return PACE_NOM;
    endfunction

    function automatic logic [DIV_W-1:0] pace_div(pace_e p);
        case (p)
            PACE_FAST: return DIV_W'(NOM_DIV - 1);
            PACE_SLOW: return DIV_W'(NOM_DIV + 1);
            default:   return DIV_W'(NOM_DIV);
        endcase
    endfunction

endpackage

// File: rtl/jsm_store.sv
module jsm_store
    import jsm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  wr_req,
    input  logic  wr_bit,
    input  logic  rd_req,
    input  fill_t depth,
    output fill_t fill,
    output logic  out_bit,
    output logic  wr_drop,
    output logic  rd_starved
);
    logic [DEEP_BITS-1:0] cells;
    fill_t wr_cnt;
    fill_t rd_cnt;
    logic  wr_go;
    logic  rd_go;

    assign fill       = wr_cnt - rd_cnt;
    assign wr_go      = wr_req && !flush && (fill < depth);
    assign wr_drop    = wr_req && !flush && (fill >= depth);
    assign rd_go      = rd_req && (fill != '0);
    assign rd_starved = rd_req && (fill == '0);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_cnt <= '0;
            rd_cnt <= '0;
        end else begin
            if (wr_go) wr_cnt <= wr_cnt + fill_t'(1);
            if (rd_go) rd_cnt <= rd_cnt + fill_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_go) cells[wr_cnt[ADDR_W-1:0]] <= wr_bit;
    end

    always_ff @(posedge clk) begin
        if (rst)        out_bit <= 1'b0;
        else if (rd_go) out_bit <= cells[rd_cnt[ADDR_W-1:0]];
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        !flush |-> fill <= depth);  // R9

    AST_WRITE_KEPT: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !flush && (fill < depth) && !rd_req) |=> fill == $past(fill) + fill_t'(1));  // R7

endmodule

// File: rtl/jsm_pacer.sv
module jsm_pacer
    import jsm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pace_e pace,
    output logic  tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= DIV_W'(NOM_DIV - 1);
        else if (tick) cnt <= pace_div(pace) - DIV_W'(1);
        else           cnt <= cnt - DIV_W'(1);
    end

    AST_RELOAD_RANGE: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt >= DIV_W'(NOM_DIV - 2)) && (cnt <= DIV_W'(NOM_DIV)));  // R4

    AST_NOM_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (tick && pace == PACE_NOM) |=> cnt == DIV_W'(NOM_DIV - 1));  // R3

endmodule

// File: rtl/jsm_steer.sv
module jsm_steer
    import jsm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   active,
    input  logic   tick,
    input  logic   clr,
    input  fill_t  fill,
    input  marks_t marks,
    output pace_e  pace,
    output logic   trip
);
    assign pace = active ? pace_pick(fill, marks) : PACE_NOM;

    always_ff @(posedge clk) begin
        if (rst)                           trip <= 1'b0;
        else if (tick && pace != PACE_NOM) trip <= 1'b1;
        else if (clr)                      trip <= 1'b0;
    end

    AST_TRIP_SET: assert property (@(posedge clk) disable iff (rst)
        (tick && pace != PACE_NOM) |=> trip);  // R5

    AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (trip && !clr) |=> trip);  // R5

    AST_TRIP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr && !(tick && pace != PACE_NOM)) |=> !trip);  // R5

endmodule

// File: rtl/jitter_smoother.sv
module jitter_smoother
    import jsm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_stb,
    input  logic wr_bit,
    input  logic deep_sel,
    input  logic bypass,
    input  logic flag_clr,
    output logic rd_stb,
    output logic rd_bit,
    output logic trip,
    output logic ovf,
    output logic udf
);
    marks_t marks;
    fill_t  fill;
    fill_t  half_lvl;
    pace_e  pace;
    logic   deep_q;
    logic   flush;
    logic   running;
    logic   tick;
    logic   rd_req;
    logic   rd_stb_q;
    logic   q_bit;
    logic   wr_drop;
    logic   starved;

    assign marks    = marks_for(deep_sel);
    assign half_lvl = marks.half;
    assign flush    = bypass || (deep_sel != deep_q);
    assign rd_req   = tick && running && !flush;

    always_ff @(posedge clk) begin
        if (rst) deep_q <= deep_sel;
        else     deep_q <= deep_sel;
    end

    always_ff @(posedge clk) begin
        if (rst || flush)          running <= 1'b0;
        else if (fill >= half_lvl) running <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) rd_stb_q <= 1'b0;
        else     rd_stb_q <= rd_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf <= 1'b0;
            udf <= 1'b0;
        end else begin
            if (wr_drop)       ovf <= 1'b1;
            else if (flag_clr) ovf <= 1'b0;
            if (starved)       udf <= 1'b1;
            else if (flag_clr) udf <= 1'b0;
        end
    end

    jsm_store u_store (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .wr_req     (wr_stb),
        .wr_bit     (wr_bit),
        .rd_req     (rd_req),
        .depth      (marks.depth),
        .fill       (fill),
        .out_bit    (q_bit),
        .wr_drop    (wr_drop),
        .rd_starved (starved)
    );

    jsm_pacer u_pacer (
        .clk  (clk),
        .rst  (rst),
        .pace (pace),
        .tick (tick)
    );

    jsm_steer u_steer (
        .clk    (clk),
        .rst    (rst),
        .active (running && !flush),
        .tick   (tick),
        .clr    (flag_clr),
        .fill   (fill),
        .marks  (marks),
        .pace   (pace),
        .trip   (trip)
    );

    assign rd_stb = bypass ? wr_stb : rd_stb_q;
    assign rd_bit = bypass ? wr_bit : q_bit;

    AST_CENTER_START: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> $past(fill) == $past(half_lvl));  // R6

    AST_STARVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_req && fill == '0) |=> (q_bit == $past(q_bit)) && udf);  // R10

endmodule

// File: tb/sim_jitter_smoother.sv
module sim_jitter_smoother;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, wr_stb, wr_bit, deep_sel, bypass, flag_clr;
    logic rd_stb, rd_bit, trip, ovf, udf;

    jitter_smoother u0 (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_bit(wr_bit),
        .deep_sel(deep_sel), .bypass(bypass), .flag_clr(flag_clr),
        .rd_stb(rd_stb), .rd_bit(rd_bit), .trip(trip), .ovf(ovf), .udf(udf)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    bit   q[$];
    bit   mon_data = 0;
    int   cyc = 0;
    int   last_rd = -1;
    int   n15 = 0, n16 = 0, n17 = 0, nother = 0;
    int   reads = 0;
    int   wr_acc = 0;
    int   first_rd_writes = -1;
    logic [15:0] lf = 16'hACE1;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit nxt();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return lf[0];
    endfunction

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (!rst && !bypass && rd_stb) begin
            reads++;
            if (first_rd_writes < 0) first_rd_writes = wr_acc;
            if (last_rd >= 0) begin
                case (cyc - last_rd)
                    15: n15++;
                    16: n16++;
                    17: n17++;
                    default: nother++;
                endcase
            end
            last_rd = cyc;
            if (mon_data) begin
                if (q.size() == 0) check(1'b0, "R7", "read with empty model", 0, 1);
                else begin
                    bit e;
                    e = q.pop_front();
                    check(rd_bit == e, "R7", "output bit order", int'(rd_bit), int'(e));
                end
            end
        end
    end

    task automatic reset_stats();
        last_rd = -1; n15 = 0; n16 = 0; n17 = 0; nother = 0;
        reads = 0; wr_acc = 0; first_rd_writes = -1;
    endtask

    task automatic put(int gap, bit b);
        @(negedge clk);
        wr_stb = 1'b1; wr_bit = b; wr_acc++;
        if (mon_data) q.push_back(b);
        @(negedge clk);
        wr_stb = 1'b0;
        repeat (gap - 2) @(negedge clk);
    endtask

    task automatic nominal(int n);
        for (int i = 0; i < n; i++) put(16, nxt());
    endtask

    task automatic wander(int amp, int rounds);
        for (int r = 0; r < rounds; r++) begin
            for (int i = 0; i < 2 * amp; i++) put(24, nxt());
            for (int i = 0; i < 4 * amp; i++) put(8, nxt());
            for (int i = 0; i < 2 * amp; i++) put(24, nxt());
        end
    endtask

    task automatic bursts(int n);
        for (int i = 0; i < n; i++) begin
            repeat (48) @(negedge clk);
            for (int j = 0; j < 4; j++) put(4, nxt());
        end
    endtask

    task automatic stream(int n);
        @(negedge clk);
        wr_stb = 1'b1;
        for (int i = 0; i < n; i++) begin
            wr_bit = nxt();
            @(negedge clk);
        end
        wr_stb = 1'b0;
    endtask

    task automatic set_depth(bit d, bit score);
        mon_data = 0;
        @(negedge clk); deep_sel = d;
        repeat (4) @(negedge clk);
        q.delete();
        reset_stats();
        mon_data = score;
    endtask

    task automatic bypass_flush(bit score);
        mon_data = 0;
        @(negedge clk); bypass = 1'b1;
        repeat (2) @(negedge clk); bypass = 1'b0;
        repeat (2) @(negedge clk);
        q.delete();
        reset_stats();
        mon_data = score;
    endtask

    task automatic pulse_clr();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1; wr_stb = 1'b0; wr_bit = 1'b0; deep_sel = 1'b0;
        bypass = 1'b0; flag_clr = 1'b0;
        repeat (4) @(negedge clk);
        check(rd_stb == 0 && trip == 0 && ovf == 0 && udf == 0, "R1", "flags in reset", 0, 0);
        rst = 1'b0;
        @(negedge clk);
        check(rd_stb == 0, "R1", "rd_stb after reset", int'(rd_stb), 0);
        check(rd_bit == 0, "R1", "rd_bit after reset", int'(rd_bit), 0);
        check(trip == 0, "R1", "trip after reset", int'(trip), 0);
        check(ovf == 0 && udf == 0, "R1", "ovf/udf after reset", int'(ovf | udf), 0);

        // shallow, wander 20 UIpp, below limit
        reset_stats(); mon_data = 1;
        nominal(20);
        wander(10, 2);
        nominal(20);
        check(first_rd_writes >= 16 && first_rd_writes <= 18, "R6", "writes before first read (shallow)", first_rd_writes, 16);
        check(nother == 0 && n15 == 0 && n17 == 0, "R3", "off-nominal intervals shallow", n15 + n17 + nother, 0);
        check(n16 > 100, "R3", "nominal intervals seen", n16, 101);
        check(trip == 0, "R11", "trip under 20 UIpp shallow", int'(trip), 0);
        check(ovf == 0 && udf == 0, "R7", "no loss shallow", int'(ovf | udf), 0);

        // switch deep: empties and restarts, bursty then 80 UIpp wander
        set_depth(1'b1, 1'b1);
        nominal(68);
        bursts(20);
        wander(40, 1);
        nominal(20);
        check(first_rd_writes >= 64 && first_rd_writes <= 66, "R2", "writes before first read (deep)", first_rd_writes, 64);
        check(nother == 0 && n15 == 0 && n17 == 0, "R3", "off-nominal intervals deep", n15 + n17 + nother, 0);
        check(trip == 0, "R11", "trip under 80 UIpp deep", int'(trip), 0);
        check(ovf == 0 && udf == 0, "R7", "no loss deep bursty", int'(ovf | udf), 0);
        check(reads > 300, "R7", "reads in deep run", reads, 301);

        // deep holds 100 back-to-back writes without drop
        bypass_flush(1'b0);
        stream(100);
        repeat (4) @(negedge clk);
        check(ovf == 0, "R2", "deep capacity takes 100 bits", int'(ovf), 0);

        // shallow, wander 32 UIpp, above limit
        set_depth(1'b0, 1'b0);
        pulse_clr();
        nominal(20);
        wander(16, 1);
        nominal(10);
        check(trip == 1, "R11", "trip over 32 UIpp shallow", int'(trip), 1);
        check(n15 + n17 > 0, "R4", "steered intervals seen", n15 + n17, 1);
        check(nother == 0, "R4", "intervals only 15/16/17", nother, 0);

        // bypass: flags held, pass-through, clear
        @(negedge clk); bypass = 1'b1;
        repeat (2) @(negedge clk);
        check(trip == 1, "R8", "trip held in bypass", int'(trip), 1);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        #1 check(trip == 0, "R5", "trip cleared by flag_clr", int'(trip), 0);
        wr_stb = 1'b1; wr_bit = 1'b1;
        #1 check(rd_stb == 1 && rd_bit == 1, "R8", "pass-through 1", int'({rd_stb, rd_bit}), 3);
        wr_bit = 1'b0;
        #1 check(rd_stb == 1 && rd_bit == 0, "R8", "pass-through 0", int'({rd_stb, rd_bit}), 2);
        wr_stb = 1'b0;
        #1 check(rd_stb == 0, "R8", "pass-through idle", int'(rd_stb), 0);
        @(negedge clk); bypass = 1'b0;
        repeat (3) @(negedge clk);
        check(trip == 0, "R5", "trip stays clear after bypass", int'(trip), 0);

        // shallow overflow
        pulse_clr();
        stream(40);
        repeat (2) @(negedge clk);
        check(ovf == 1, "R9", "ovf after 40 back-to-back in 32-bit buffer", int'(ovf), 1);
        check(ovf == 1, "R2", "shallow capacity below 40", int'(ovf), 1);
        pulse_clr();
        check(ovf == 0, "R9", "ovf cleared", int'(ovf), 0);

        // underflow: 16 alternating bits then silence
        bypass_flush(1'b0);
        pulse_clr();
        reset_stats();
        for (int k = 0; k < 16; k++) put(16, bit'(k % 2));
        repeat (480) @(negedge clk);
        check(udf == 1, "R10", "udf after drain", int'(udf), 1);
        check(rd_bit == 1, "R10", "last bit repeated", int'(rd_bit), 1);
        check(reads >= 20, "R10", "strobes continue when empty", reads, 20);

        summary();
    end
endmodule